// File: doc/BRIEF.md
# Transmit/Receive Byte FIFO Pair with Self-Clearing Flush

This block holds two byte FIFOs between a register-mapped host port and a serial shift engine. The transmit FIFO takes bytes from the host and hands them to the engine. The receive FIFO takes bytes from the engine and hands them to the host. Each FIFO reports its occupancy and a set of level flags for an interrupt unit. One flag compares the occupancy against a programmable threshold from 0 to 15. A single-cycle overrun event is raised when the host writes into a full transmit FIFO.

The control word has one flush bit per FIFO: bit 7 for transmit and bit 8 for receive. Writing a 1 to a flush bit starts a flush that lasts several cycles. While the flush runs, the FIFO reads as empty and ignores every push and pop. The bit clears itself when the flush ends. A small state machine runs each flush. Its states are FL_IDLE and FL_RUN. Its transitions are START, from FL_IDLE to FL_RUN when the bit is written as 1, and DONE, from FL_RUN to FL_IDLE once the cycle count is reached.

The head of each FIFO is visible on its read port without any delay. A pop takes effect at the clock edge.

Top module: `byte_fifo_pair`

## Requirements
- R1: After reset, both FIFOs are empty with level 0, both flush bits read 0, and tx_overrun is 0.
- R2: Bytes leave each FIFO in the order they entered. The oldest byte is presented on eng_tx_data (transmit) or host_rx_data (receive). The level rises by one for an accepted push and falls by one for an accepted pop, and both can happen in the same cycle.
- R3: A push into a FIFO holding DEPTH (16) bytes is dropped, even when a pop happens in the same cycle. The level and the stored bytes are unchanged by the dropped push.
- R4: When host_tx_wr is high, the transmit FIFO is full and no transmit flush is running or starting, tx_overrun is high for exactly the next cycle. In every other case tx_overrun is 0.
- R5: A pop from an empty FIFO leaves the level at 0. The read data of an empty FIFO is 0.
- R6: An empty flag is 1 exactly when its level is 0. A full flag is 1 exactly when its level equals DEPTH.
- R7: tx_nearly_empty is 1 exactly when tx_level is less than or equal to tx_thresh.
- R8: rx_nearly_full is 1 exactly when rx_level is greater than or equal to rx_thresh.
- R9: A cycle with ctrl_wr high and ctrl_wdata bit 7 (transmit) or bit 8 (receive) set starts a flush of that FIFO when it is idle. The matching ctrl_rdata bit then reads 1 for exactly FLUSH_CYCLES (4) cycles and clears itself. The level of that FIFO reads 0 from the cycle after the request.
- R10: Pushes and pops to a FIFO in its request cycle or while it is flushing have no effect, and the FIFO is empty once the flush ends. The other FIFO is not affected.
- R11: Writing a flush bit as 0 never stops a running flush. Writing it as 1 during a flush does not restart or lengthen that flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 2 | Control bits [8:7]: bit 8 requests a receive flush, bit 7 a transmit flush |
| ctrl_rdata | output | 2 | Flush-in-progress bits [8:7], self-clearing |
| tx_thresh | input | 4 | Transmit threshold (0..15) |
| rx_thresh | input | 4 | Receive threshold (0..15) |
| host_tx_wr | input | 1 | Host pushes a byte into the transmit FIFO |
| host_tx_data | input | 8 | Byte pushed by the host |
| host_rx_rd | input | 1 | Host pops the receive FIFO |
| host_rx_data | output | 8 | Oldest receive byte, 0 when empty |
| eng_tx_rd | input | 1 | Engine pops the transmit FIFO |
| eng_tx_data | output | 8 | Oldest transmit byte, 0 when empty |
| eng_rx_wr | input | 1 | Engine pushes a byte into the receive FIFO |
| eng_rx_data | input | 8 | Byte pushed by the engine |
| tx_level | output | 5 | Transmit occupancy |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_nearly_empty | output | 1 | Transmit occupancy at or below tx_thresh |
| tx_full | output | 1 | Transmit FIFO full |
| tx_overrun | output | 1 | One-cycle event: host write into full transmit FIFO |
| rx_level | output | 5 | Receive occupancy |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_nearly_full | output | 1 | Receive occupancy at or above rx_thresh |
| rx_full | output | 1 | Receive FIFO full |

## Verification
The bench uses the defaults: DEPTH 16, WIDTH 8 and FLUSH_CYCLES 4. With only 16 entries, the random traffic often reaches both full and empty. That makes dropped pushes, overruns, reads from an empty FIFO and simultaneous push/pop at the boundaries common. The thresholds are redrawn across the whole 0..15 range, including both ends. A four-cycle flush is short enough that the random requests often overlap host or engine traffic and repeated flush writes.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;
    typedef enum logic {
        FL_IDLE = 1'b0,
        FL_RUN  = 1'b1
    } flush_state_t;

    localparam int unsigned TX_IDX       = 0;
    localparam int unsigned RX_IDX       = 1;
    localparam int unsigned TX_FLUSH_BIT = 7;
    localparam int unsigned RX_FLUSH_BIT = 8;
endpackage

// File: rtl/fifo_flush_fsm.sv
module fifo_flush_fsm
    import fifo_pair_pkg::*;
#(
    parameter int unsigned FLUSH_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic clear
);
    localparam int unsigned CW = (FLUSH_CYCLES > 1) ? $clog2(FLUSH_CYCLES) : 1;

    flush_state_t state, nxt;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FL_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == FL_IDLE) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            FL_IDLE: if (start) nxt = FL_RUN;                        // START
            FL_RUN:  if (cnt == CW'(FLUSH_CYCLES - 1)) nxt = FL_IDLE; // DONE
            default: nxt = FL_IDLE;
        endcase
    end

    always_comb begin
        busy  = (state == FL_RUN);
        clear = busy | start;
    end
endmodule

// File: rtl/fifo_core.sv
module fifo_core #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         push,
    input  logic [WIDTH-1:0]             push_data,
    input  logic                         pop,
    output logic [WIDTH-1:0]             head_data,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned LW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push & ~clear & ~full;
    assign pop_ok  = pop & ~clear & ~empty;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wrap_inc(wr_ptr);
            if (pop_ok)  rd_ptr <= wrap_inc(rd_ptr);
            level <= level + LW'(push_ok) - LW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    assign head_data = empty ? '0 : mem[rd_ptr];
endmodule

// File: rtl/byte_fifo_pair.sv
module byte_fifo_pair
    import fifo_pair_pkg::*;
#(
    parameter int unsigned DEPTH        = 16,
    parameter int unsigned WIDTH        = 8,
    parameter int unsigned FLUSH_CYCLES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ctrl_wr,
    input  logic [8:7]                 ctrl_wdata,
    output logic [8:7]                 ctrl_rdata,
    input  logic [$clog2(DEPTH)-1:0]   tx_thresh,
    input  logic [$clog2(DEPTH)-1:0]   rx_thresh,
    input  logic                       host_tx_wr,
    input  logic [WIDTH-1:0]           host_tx_data,
    input  logic                       host_rx_rd,
    output logic [WIDTH-1:0]           host_rx_data,
    input  logic                       eng_tx_rd,
    output logic [WIDTH-1:0]           eng_tx_data,
    input  logic                       eng_rx_wr,
    input  logic [WIDTH-1:0]           eng_rx_data,
    output logic [$clog2(DEPTH+1)-1:0] tx_level,
    output logic                       tx_empty,
    output logic                       tx_nearly_empty,
    output logic                       tx_full,
    output logic                       tx_overrun,
    output logic [$clog2(DEPTH+1)-1:0] rx_level,
    output logic                       rx_empty,
    output logic                       rx_nearly_full,
    output logic                       rx_full
);
    localparam int unsigned LW = $clog2(DEPTH + 1);

    logic [1:0]       fl_start, fl_busy, fl_clear;
    logic [1:0]       q_push, q_pop, q_full, q_empty;
    logic [WIDTH-1:0] q_din  [2];
    logic [WIDTH-1:0] q_head [2];
    logic [LW-1:0]    q_level[2];

    assign q_push[TX_IDX] = host_tx_wr;
    assign q_din[TX_IDX]  = host_tx_data;
    assign q_pop[TX_IDX]  = eng_tx_rd;
    assign q_push[RX_IDX] = eng_rx_wr;
    assign q_din[RX_IDX]  = eng_rx_data;
    assign q_pop[RX_IDX]  = host_rx_rd;

    generate
        for (genvar i = 0; i < 2; i++) begin : g_q
            localparam int unsigned FB = (i == 0) ? TX_FLUSH_BIT : RX_FLUSH_BIT;

            assign fl_start[i] = ctrl_wr & ctrl_wdata[FB];

            fifo_flush_fsm #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_flush (
                .clk   (clk),
                .rst_n (rst_n),
                .start (fl_start[i]),
                .busy  (fl_busy[i]),
                .clear (fl_clear[i])
            );

            fifo_core #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
                .clk       (clk),
                .rst_n     (rst_n),
                .clear     (fl_clear[i]),
                .push      (q_push[i]),
                .push_data (q_din[i]),
                .pop       (q_pop[i]),
                .head_data (q_head[i]),
                .level     (q_level[i]),
                .full      (q_full[i]),
                .empty     (q_empty[i])
            );
        end
    endgenerate

    assign ctrl_rdata[TX_FLUSH_BIT] = fl_busy[TX_IDX];
    assign ctrl_rdata[RX_FLUSH_BIT] = fl_busy[RX_IDX];

    assign eng_tx_data     = q_head[TX_IDX];
    assign tx_level        = q_level[TX_IDX];
    assign tx_empty        = q_empty[TX_IDX];
    assign tx_full         = q_full[TX_IDX];
    assign tx_nearly_empty = (q_level[TX_IDX] <= LW'(tx_thresh));

    assign host_rx_data    = q_head[RX_IDX];
    assign rx_level        = q_level[RX_IDX];
    assign rx_empty        = q_empty[RX_IDX];
    assign rx_full         = q_full[RX_IDX];
    assign rx_nearly_full  = (q_level[RX_IDX] >= LW'(rx_thresh));

    always_ff @(posedge clk) begin
        if (!rst_n) tx_overrun <= 1'b0;
        else        tx_overrun <= host_tx_wr & q_full[TX_IDX] & ~fl_clear[TX_IDX];
    end
endmodule

// File: rtl/fifo_pair_chk.sv
module fifo_pair_chk #(
    parameter int unsigned DEPTH        = 16,
    parameter int unsigned WIDTH        = 8,
    parameter int unsigned FLUSH_CYCLES = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ctrl_wr,
    input logic [8:7]                 ctrl_wdata,
    input logic [8:7]                 ctrl_rdata,
    input logic [$clog2(DEPTH)-1:0]   tx_thresh,
    input logic [$clog2(DEPTH)-1:0]   rx_thresh,
    input logic                       host_tx_wr,
    input logic [WIDTH-1:0]           host_tx_data,
    input logic                       host_rx_rd,
    input logic [WIDTH-1:0]           host_rx_data,
    input logic                       eng_tx_rd,
    input logic [WIDTH-1:0]           eng_tx_data,
    input logic                       eng_rx_wr,
    input logic [WIDTH-1:0]           eng_rx_data,
    input logic [$clog2(DEPTH+1)-1:0] tx_level,
    input logic                       tx_empty,
    input logic                       tx_nearly_empty,
    input logic                       tx_full,
    input logic                       tx_overrun,
    input logic [$clog2(DEPTH+1)-1:0] rx_level,
    input logic                       rx_empty,
    input logic                       rx_nearly_full,
    input logic                       rx_full
);
    AST_FLUSH_TX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[7] |-> (tx_level == 0)); // R9
    AST_FLUSH_RX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[8] |-> (rx_level == 0)); // R9
    AST_FLUSH_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_wdata[7] && !ctrl_rdata[7]) |=> ctrl_rdata[7]); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= DEPTH) && (rx_level <= DEPTH)); // R3
    AST_OVERRUN_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (host_tx_wr && tx_full && !ctrl_rdata[7] && !(ctrl_wr && ctrl_wdata[7])) |=> tx_overrun); // R4
    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |-> (host_rx_data == 0)); // R5
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_tx_wr && !eng_tx_rd && !ctrl_rdata[7] && !ctrl_wr) |=> $stable(tx_level)); // R2
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty) && !(rx_full && rx_empty)); // R6
endmodule

bind byte_fifo_pair fifo_pair_chk #(
    .DEPTH(DEPTH), .WIDTH(WIDTH), .FLUSH_CYCLES(FLUSH_CYCLES)
) u_chk (.*);

// File: tb/byte_fifo_pair_tb.sv
`timescale 1ns/1ps
module byte_fifo_pair_tb;
    localparam int DEPTH = 16;
    localparam int FC    = 4;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       ctrl_wr = 0;
    logic [8:7] ctrl_wdata = '0;
    logic [8:7] ctrl_rdata;
    logic [3:0] tx_thresh = 0, rx_thresh = 0;
    logic       host_tx_wr = 0, host_rx_rd = 0, eng_tx_rd = 0, eng_rx_wr = 0;
    logic [7:0] host_tx_data = 0, eng_rx_data = 0;
    logic [7:0] host_rx_data, eng_tx_data;
    logic [4:0] tx_level, rx_level;
    logic       tx_empty, tx_nearly_empty, tx_full, tx_overrun;
    logic       rx_empty, rx_nearly_full, rx_full;

    byte_fifo_pair u_dut (.*);

    always #2 clk = ~clk;

    int checks = 0, errors = 0;
    logic [7:0] txq [DEPTH];
    logic [7:0] rxq [DEPTH];
    int txn = 0, rxn = 0, tx_rem = 0, rx_rem = 0;
    bit exp_ovr = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int head_of(input logic [7:0] q [DEPTH], input int n);
        return (n == 0) ? 0 : int'(q[0]);
    endfunction

    task automatic check_post();
        chk(tx_level == txn, "R2 tx_level", tx_level, txn);
        chk(rx_level == rxn, "R2 rx_level", rx_level, rxn);
        chk(tx_empty == (txn == 0), "R6 tx_empty", tx_empty, txn == 0);
        chk(tx_full == (txn == DEPTH), "R6 tx_full", tx_full, txn == DEPTH);
        chk(rx_empty == (rxn == 0), "R6 rx_empty", rx_empty, rxn == 0);
        chk(rx_full == (rxn == DEPTH), "R6 rx_full", rx_full, rxn == DEPTH);
        chk(tx_nearly_empty == (txn <= int'(tx_thresh)), "R7 tx_nearly_empty",
            tx_nearly_empty, txn <= int'(tx_thresh));
        chk(rx_nearly_full == (rxn >= int'(rx_thresh)), "R8 rx_nearly_full",
            rx_nearly_full, rxn >= int'(rx_thresh));
        chk(tx_overrun == exp_ovr, "R4 tx_overrun", tx_overrun, exp_ovr);
        chk(ctrl_rdata[7] == (tx_rem > 0), "R9 tx flush bit", ctrl_rdata[7], tx_rem > 0);
        chk(ctrl_rdata[8] == (rx_rem > 0), "R9 rx flush bit", ctrl_rdata[8], rx_rem > 0);
        chk(int'(eng_tx_data) == head_of(txq, txn), "R2 eng_tx_data", eng_tx_data, head_of(txq, txn));
        chk(int'(host_rx_data) == head_of(rxq, rxn), "R2 host_rx_data", host_rx_data, head_of(rxq, rxn));
    endtask

    task automatic model_fifo(inout logic [7:0] q [DEPTH], inout int n, inout int rem,
                              input bit start, input bit push, input logic [7:0] d,
                              input bit pop, output bit drop);
        bit clr = (rem > 0) || start;
        bit was_full = (n == DEPTH);
        drop = 0;
        if (rem > 0) rem--;
        else if (start) rem = FC;
        if (clr) begin
            n = 0;
        end else begin
            drop = push && was_full;
            if (pop && n > 0) begin
                for (int k = 0; k < DEPTH - 1; k++) q[k] = q[k + 1];
                n--;
            end
            if (push && !was_full) begin
                q[n] = d;
                n++;
            end
        end
    endtask

    // one cycle: drive at negedge, update model at the edge, check at next negedge
    task automatic step(input bit twr, input logic [7:0] td, input bit trd,
                        input bit rwr, input logic [7:0] rd_d, input bit rrd,
                        input bit cwr, input logic [1:0] cw);
        bit d0, d1;
        host_tx_wr = twr; host_tx_data = td; eng_tx_rd = trd;
        eng_rx_wr = rwr; eng_rx_data = rd_d; host_rx_rd = rrd;
        ctrl_wr = cwr; ctrl_wdata = cw;
        @(posedge clk);
        model_fifo(txq, txn, tx_rem, cwr && cw[0], twr, td, trd, d0);
        model_fifo(rxq, rxn, rx_rem, cwr && cw[1], rwr, rd_d, rrd, d1);
        exp_ovr = d0;
        @(negedge clk);
        host_tx_wr = 0; eng_tx_rd = 0; eng_rx_wr = 0; host_rx_rd = 0; ctrl_wr = 0; ctrl_wdata = '0;
        check_post();
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(tx_level == 0 && rx_level == 0, "R1 levels", tx_level + rx_level, 0);
        chk(tx_empty && rx_empty, "R1 empty flags", {tx_empty, rx_empty}, 3);
        chk(ctrl_rdata == 2'b00, "R1 flush bits", ctrl_rdata, 0);
        chk(tx_overrun == 0, "R1 overrun", tx_overrun, 0);
        check_post();

        tx_thresh = 3; rx_thresh = 5;
        // fill transmit FIFO
        for (int i = 0; i < DEPTH; i++) step(1, 8'(i * 17 + 1), 0, 0, 0, 0, 0, 2'b00);
        // R3/R4: write into full FIFO, then full with simultaneous pop
        step(1, 8'hEE, 0, 0, 0, 0, 0, 2'b00);
        chk(tx_overrun == 1, "R4 overrun after full write", tx_overrun, 1);
        chk(tx_level == DEPTH, "R3 level unchanged", tx_level, DEPTH);
        step(0, 0, 0, 0, 0, 0, 0, 2'b00);
        chk(tx_overrun == 0, "R4 overrun one cycle only", tx_overrun, 0);
        step(1, 8'hDD, 1, 0, 0, 0, 0, 2'b00);
        chk(tx_level == DEPTH - 1, "R3 push dropped with pop", tx_level, DEPTH - 1);
        // drain in order
        for (int i = 0; i < DEPTH - 1; i++) step(0, 0, 1, 0, 0, 0, 0, 2'b00);
        // R5: pop on empty
        step(0, 0, 1, 0, 0, 0, 0, 2'b00);
        chk(tx_level == 0 && eng_tx_data == 0, "R5 tx empty pop", tx_level, 0);

        // receive path and empty read
        for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 8'(8'hA0 + i), 0, 0, 2'b00);
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 1, 0, 2'b00);
        chk(rx_level == 0 && host_rx_data == 0, "R5 rx empty read", host_rx_data, 0);

        // R10/R11: flush tx with traffic, rx untouched
        for (int i = 0; i < 6; i++) step(1, 8'(8'h30 + i), 0, 0, 0, 0, 0, 2'b00);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 8'(8'h50 + i), 0, 0, 2'b00);
        step(1, 8'h77, 0, 0, 0, 0, 1, 2'b01);
        chk(tx_level == 0 && ctrl_rdata[7], "R9 flush started", tx_level, 0);
        step(1, 8'h78, 1, 0, 0, 0, 1, 2'b00);
        step(1, 8'h79, 0, 0, 0, 0, 1, 2'b01);
        step(1, 8'h7A, 1, 0, 0, 0, 0, 2'b00);
        step(0, 0, 0, 0, 0, 0, 0, 2'b00);
        chk(ctrl_rdata[7] == 0, "R11 flush not extended", ctrl_rdata[7], 0);
        chk(tx_level == 0, "R10 tx empty after flush", tx_level, 0);
        chk(rx_level == 3, "R10 rx untouched", rx_level, 3);
        step(0, 0, 0, 0, 0, 0, 1, 2'b10);
        for (int i = 0; i < FC; i++) step(0, 0, 0, 1, 8'h11, 1, 0, 2'b00);
        chk(rx_level == 0 && ctrl_rdata[8] == 0, "R10 rx flushed", rx_level, 0);

        // threshold extremes
        tx_thresh = 0; rx_thresh = 15;
        step(0, 0, 0, 0, 0, 0, 0, 2'b00);
        tx_thresh = 15; rx_thresh = 0;
        step(0, 0, 0, 0, 0, 0, 0, 2'b00);

        // constrained random traffic
        for (int c = 0; c < 4000; c++) begin
            if (c % 200 == 0) begin
                tx_thresh = 4'($urandom_range(0, 15));
                rx_thresh = 4'($urandom_range(0, 15));
            end
            step($urandom_range(0, 99) < 55, 8'($urandom), $urandom_range(0, 99) < 45,
                 $urandom_range(0, 99) < 50, 8'($urandom), $urandom_range(0, 99) < 50,
                 $urandom_range(0, 63) == 0, 2'($urandom_range(0, 3)));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule